// File: doc/BRIEF.md
# PLL Lock Timer Controller

This block holds the configuration of one frequency-multiplying PLL and decides, without any phase detector, when that PLL is to be treated as locked. Software writes a divider, a multiplier, an enable bit, a lock-wait count and a halving status bit in one access. The block reports whether the PLL is powered and whether its reference path is open. It also reports the frequency ratio as a numerator (multiplier plus one) and a denominator (the divider).

Lock comes from a software-loaded countdown paced by a slow-clock tick. A write that turns the PLL on, or that changes its divider or multiplier, clears the lock flag and reloads the countdown. The flag rises once the countdown has run out. An interrupt line shows the lock flag through a mask that is set and cleared by separate write-one strobes.

The controller is a three-state machine.
- **OFF**: the PLL is powered down, the counter is held at zero and lock is low.
- **WAIT**: the countdown is running.
- **LOCKED**: lock is high.

The transitions are as follows.
- **START** (OFF to WAIT): a write that activates the PLL.
- **EXPIRE** (WAIT to LOCKED): a slow-clock tick arrives while the counter is zero.
- **RELOAD** (WAIT or LOCKED to WAIT): a write that keeps the PLL active but changes its divider or multiplier.
- **STOP** (any state to OFF): a write with a zero multiplier or a clear enable bit.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset the divider, multiplier, enable, count and halving fields are 0. pll_on, ref_en, lock, irq, irq_mask and half_out are all 0.
- R2: ref_en is 1 exactly when the stored divider is nonzero. ratio_num equals the stored multiplier plus one, and ratio_den equals the stored divider. All three follow a write from the clock edge that takes it.
- R3: pll_on is 1 exactly when the stored enable bit is 1 and the stored multiplier is nonzero.
- R4: A write is a restart when it leaves the PLL active and the PLL was previously inactive or the written divider or multiplier differs from the stored one.
  - A restart clears lock on its own edge and loads the written count N.
  - lock then rises on the edge of the (N+1)th slow tick after that write, so a count of 0 locks on the first tick.
- R5: While pll_on is 0, lock stays 0 and slow ticks have no effect. Re-enabling restarts the full count.
- R6: A write that keeps the PLL active with the same divider and multiplier is not a restart. It leaves lock and a running countdown untouched, and the newly written count is used only at the next restart.
- R7: A slow tick in the same cycle as any write is ignored. For a restart, the fresh count is loaded and no tick is taken from it.
- R8: half_out holds the written halving bit and has no effect on the lock timing.
- R9: The interrupt mask is controlled by two strobes.
  - irq_set sets the mask and irq_clr clears it. When both are high in the same cycle, clear wins.
  - irq_mask shows the mask, and irq is high exactly while lock and the mask are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | DIV_W | Divider value to write |
| cfg_mul | input | MUL_W | Multiplier value to write |
| cfg_en | input | 1 | Enable bit to write |
| cfg_cnt | input | CNT_W | Lock-wait count to write |
| cfg_half | input | 1 | Halving status bit to write |
| slow_tick | input | 1 | One-cycle slow-clock tick |
| irq_set | input | 1 | Write-one-to-set the interrupt mask |
| irq_clr | input | 1 | Write-one-to-clear the interrupt mask |
| pll_on | output | 1 | PLL powered and active |
| ref_en | output | 1 | Divided reference running (divider nonzero) |
| ratio_num | output | MUL_W+1 | Frequency ratio numerator |
| ratio_den | output | DIV_W | Frequency ratio denominator |
| half_out | output | 1 | Stored halving bit |
| lock | output | 1 | Lock flag |
| irq_mask | output | 1 | Interrupt mask |
| irq | output | 1 | Level interrupt, lock AND mask |

## Verification
The countdown is tried with counts 0, 1 and 3, so an off-by-one between N and N+1 ticks shows up as an early or a late lock. Parameter writes are split into three kinds: restarting writes (enable from off, divider change, multiplier change), a same-parameter write landing mid-count, and disabling writes (zero multiplier, clear enable). Each kind tells whether the counter reloads, keeps running or is forced off. Writes coincident with ticks, both restarting and not, separate correct write priority from a tick that leaks through. The mask strobes are applied alone and together, with lock both high and low.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [MUL_W-1:0] cfg_mul,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cfg_half,
    output logic [DIV_W-1:0] div_q,
    output logic [MUL_W-1:0] mul_q,
    output logic             en_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             half_q,
    output logic             restart,
    output logic             shutdown
);
    logic wr_active;
    logic cur_active;

    always_comb begin
        wr_active  = cfg_en && (cfg_mul != '0);
        cur_active = en_q && (mul_q != '0);
        restart    = cfg_we && wr_active &&
                     (!cur_active || (cfg_div != div_q) || (cfg_mul != mul_q));
        shutdown   = cfg_we && !wr_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            mul_q  <= '0;
            en_q   <= 1'b0;
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (cfg_we) begin
            div_q  <= cfg_div;
            mul_q  <= cfg_mul;
            en_q   <= cfg_en;
            cnt_q  <= cfg_cnt;
            half_q <= cfg_half;
        end
    end
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_lock_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             restart,
    input  logic             shutdown,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             lock
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lock_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tick_ok;

    always_comb begin
        tick_ok = tick && !wr;
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (restart) begin          // START
                    state_d = ST_WAIT;
                    cnt_d   = load_val;
                end
            end
            ST_WAIT: begin
                if (shutdown) begin         // STOP
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (restart) begin // RELOAD
                    cnt_d = load_val;
                end else if (tick_ok) begin
                    if (cnt_q == '0) begin  // EXPIRE
                        state_d = ST_LOCKED;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
            end
            ST_LOCKED: begin
                if (shutdown) begin         // STOP
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (restart) begin // RELOAD
                    state_d = ST_WAIT;
                    cnt_d   = load_val;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        lock = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/pll_irq_mask.sv
module pll_irq_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic lock,
    output logic mask_q,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= 1'b0;
        else if (clr_i)  mask_q <= 1'b0;
        else if (set_i)  mask_q <= 1'b1;
    end

    always_comb irq = lock && mask_q;
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [MUL_W-1:0] cfg_mul,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cfg_half,
    input  logic             slow_tick,
    input  logic             irq_set,
    input  logic             irq_clr,
    output logic             pll_on,
    output logic             ref_en,
    output logic [MUL_W:0]   ratio_num,
    output logic [DIV_W-1:0] ratio_den,
    output logic             half_out,
    output logic             lock,
    output logic             irq_mask,
    output logic             irq
);
    localparam logic [MUL_W:0] NUM_ONE = (MUL_W+1)'(1);

    logic [DIV_W-1:0] div_q;
    logic [MUL_W-1:0] mul_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             shutdown;

    pll_cfg_regs #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_div(cfg_div), .cfg_mul(cfg_mul), .cfg_en(cfg_en),
        .cfg_cnt(cfg_cnt), .cfg_half(cfg_half),
        .div_q(div_q), .mul_q(mul_q), .en_q(en_q), .cnt_q(cnt_q),
        .half_q(half_out), .restart(restart), .shutdown(shutdown)
    );

    pll_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(cfg_we), .restart(restart),
        .shutdown(shutdown), .load_val(cfg_cnt), .tick(slow_tick),
        .lock(lock)
    );

    pll_irq_mask u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr),
        .lock(lock), .mask_q(irq_mask), .irq(irq)
    );

    always_comb begin
        pll_on    = en_q && (mul_q != '0);
        ref_en    = (div_q != '0);
        ratio_num = {1'b0, mul_q} + NUM_ONE;
        ratio_den = div_q;
    end
endmodule

// File: rtl/pll_lock_ctrl_chk.sv
module pll_lock_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [DIV_W-1:0] cfg_div,
    input logic             slow_tick,
    input logic             irq_set,
    input logic             irq_clr,
    input logic             pll_on,
    input logic             ref_en,
    input logic             lock,
    input logic             irq,
    input logic             irq_mask,
    input logic             restart
);
    // R5
    lock_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> !lock);

    // R4
    restart_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock);

    // R7
    lock_on_clean_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(slow_tick) && !$past(cfg_we)));

    // R2
    zero_div_gates_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_div == '0) |=> !ref_en);

    // R9
    mask_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (!irq_mask && !irq));

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set && !irq_clr) |=> irq_mask);
endmodule

bind pll_lock_ctrl pll_lock_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .slow_tick(slow_tick), .irq_set(irq_set), .irq_clr(irq_clr),
    .pll_on(pll_on), .ref_en(ref_en), .lock(lock), .irq(irq),
    .irq_mask(irq_mask), .restart(restart)
);

// File: tb/pll_lock_ctrl_test.sv
`timescale 1ns/1ps
module pll_lock_ctrl_test;
    localparam int DIV_W = 8;
    localparam int MUL_W = 11;
    localparam int CNT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [MUL_W-1:0] cfg_mul = '0;
    logic cfg_en = 1'b0;
    logic [CNT_W-1:0] cfg_cnt = '0;
    logic cfg_half = 1'b0;
    logic slow_tick = 1'b0;
    logic irq_set = 1'b0;
    logic irq_clr = 1'b0;
    logic pll_on, ref_en, half_out, lock, irq_mask, irq;
    logic [MUL_W:0] ratio_num;
    logic [DIV_W-1:0] ratio_den;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pll_lock_ctrl #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_mul(cfg_mul), .cfg_en(cfg_en), .cfg_cnt(cfg_cnt),
        .cfg_half(cfg_half), .slow_tick(slow_tick), .irq_set(irq_set),
        .irq_clr(irq_clr), .pll_on(pll_on), .ref_en(ref_en),
        .ratio_num(ratio_num), .ratio_den(ratio_den), .half_out(half_out),
        .lock(lock), .irq_mask(irq_mask), .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic wr(input logic [DIV_W-1:0] d, input logic [MUL_W-1:0] m,
                      input logic e, input logic [CNT_W-1:0] c,
                      input logic h, input logic tk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_div = d; cfg_mul = m; cfg_en = e;
        cfg_cnt = c; cfg_half = h; slow_tick = tk;
        @(negedge clk);
        cfg_we = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic mask_op(input logic s, input logic c);
        @(negedge clk); irq_set = s; irq_clr = c;
        @(negedge clk); irq_set = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 pll_on", pll_on, 0);
        chk("R1 ref_en", ref_en, 0);
        chk("R1 lock", lock, 0);
        chk("R1 irq", irq, 0);
        chk("R1 irq_mask", irq_mask, 0);
        chk("R1 half_out", half_out, 0);
        chk("R1 ratio_num", ratio_num, 1);
        ticks(2);
        chk("R5 ticks while off", lock, 0);
    endtask

    task automatic t_count3;
        wr(8'd4, 11'd9, 1'b1, 6'd3, 1'b0, 1'b0);
        chk("R3 pll_on", pll_on, 1);
        chk("R2 ref_en", ref_en, 1);
        chk("R2 ratio_num", ratio_num, 10);
        chk("R2 ratio_den", ratio_den, 4);
        chk("R4 lock after start", lock, 0);
        ticks(3);
        chk("R4 not locked after N ticks", lock, 0);
        ticks(1);
        chk("R4 locked after N+1 ticks", lock, 1);
    endtask

    task automatic t_change_div;
        wr(8'd5, 11'd9, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R4 div change clears lock", lock, 0);
        ticks(1);
        chk("R4 count 0 locks on first tick", lock, 1);
        wr(8'd5, 11'd12, 1'b1, 6'd1, 1'b0, 1'b0);
        chk("R4 mul change clears lock", lock, 0);
        ticks(1);
        chk("R4 count 1 not yet", lock, 0);
        ticks(1);
        chk("R4 count 1 locks on second tick", lock, 1);
    endtask

    task automatic t_same_params;
        wr(8'd5, 11'd12, 1'b1, 6'd0, 1'b1, 1'b0);
        chk("R6 same-param write keeps lock", lock, 1);
        chk("R8 half_out stored", half_out, 1);
        wr(8'd6, 11'd12, 1'b1, 6'd3, 1'b1, 1'b0);
        ticks(2);
        wr(8'd6, 11'd12, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R8 half_out cleared", half_out, 0);
        ticks(1);
        chk("R6 countdown not reloaded by new count", lock, 0);
        ticks(1);
        chk("R6 countdown continued", lock, 1);
    endtask

    task automatic t_disable;
        wr(8'd6, 11'd0, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R3 mul zero powers off", pll_on, 0);
        chk("R5 lock off on mul zero", lock, 0);
        ticks(3);
        chk("R5 ticks ignored while off", lock, 0);
        wr(8'd6, 11'd7, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R3 enable clear powers off", pll_on, 0);
        ticks(2);
        chk("R5 en clear keeps lock low", lock, 0);
        wr(8'd6, 11'd7, 1'b1, 6'd2, 1'b0, 1'b0);
        ticks(2);
        chk("R5 re-enable full count pending", lock, 0);
        ticks(1);
        chk("R5 re-enable locks after full count", lock, 1);
    endtask

    task automatic t_priority;
        wr(8'd3, 11'd7, 1'b1, 6'd1, 1'b0, 1'b1);
        chk("R7 restart with tick clears lock", lock, 0);
        ticks(1);
        chk("R7 tick at restart not counted", lock, 0);
        ticks(1);
        chk("R7 lock after full count", lock, 1);
        wr(8'd2, 11'd7, 1'b1, 6'd1, 1'b0, 1'b0);
        ticks(1);
        wr(8'd2, 11'd7, 1'b1, 6'd1, 1'b0, 1'b1);
        chk("R7 tick with plain write ignored", lock, 0);
        ticks(1);
        chk("R7 next tick locks", lock, 1);
    endtask

    task automatic t_div_zero;
        wr(8'd0, 11'd7, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R2 divider zero gates ref", ref_en, 0);
        chk("R2 ratio_den zero", ratio_den, 0);
        wr(8'd255, 11'd2047, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R2 max divider ref on", ref_en, 1);
        chk("R2 max ratio_num", ratio_num, 2048);
        ticks(1);
    endtask

    task automatic t_irq;
        chk("R9 lock before irq test", lock, 1);
        chk("R9 irq masked", irq, 0);
        mask_op(1'b1, 1'b0);
        chk("R9 mask set", irq_mask, 1);
        chk("R9 irq with lock and mask", irq, 1);
        wr(8'd9, 11'd2047, 1'b1, 6'd0, 1'b0, 1'b0);
        chk("R9 irq drops with lock", irq, 0);
        ticks(1);
        chk("R9 irq returns with lock", irq, 1);
        mask_op(1'b1, 1'b1);
        chk("R9 clear wins over set", irq_mask, 0);
        chk("R9 irq off after clear", irq, 0);
        mask_op(1'b1, 1'b0);
        mask_op(1'b0, 1'b1);
        chk("R9 plain clear", irq_mask, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count3();
        t_change_div();
        t_same_params();
        t_disable();
        t_priority();
        t_div_zero();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule